// File: doc/BRIEF.md
# CAS Signaling Freeze and Realignment Buffer

This block sits on the receive side of an E1 framer, behind the elastic store, in the 2.048 MHz backplane clock domain. It takes the four-bit ABCD channel-associated signaling nibbles that are pulled out of timeslot 16 and stores them in a buffer that holds two multiframes. One half is written while the other, holding the last complete multiframe, is read. Each time the user pulses the backplane multiframe sync, the stored signaling is sent out serially. This retimes the signaling to a multiframe boundary chosen by the system rather than by the line, with about one multiframe of delay.

Loss of frame alignment, carrier loss or a frame slip corrupts the incoming signaling. When freeze is enabled, any of these faults blocks all writes and all half swaps, so the replay keeps repeating the last good multiframe. Software can force the same freeze at any time. After every fault input has gone low, the freeze stays in place for a further `HOLD_CYCLES` clocks (8192 by default, which is 4 ms at 2.048 MHz) before new signaling may be stored.

The nibble input is a valid/ready stream. Ready is held high at all times because the line side cannot be stalled. A nibble offered while the buffer is frozen is accepted and then discarded. The serial output has a valid qualifier but no ready, because the backplane timing cannot wait.

Top module: `cas_realign_buf`

## Requirements
- R1: A nibble presented with `sig_valid` high while not frozen is stored at index `sig_ch` of the write half. `sig_ready` is always 1, and a nibble offered while frozen is dropped.
- R2: A `rx_mf_end` pulse while not frozen publishes the write half by swapping the halves. This happens only if no freeze occurred since the previous boundary. The first boundary after reset, or after a freeze, only arms the next one.
- R3: With `reins_en` high, a `bp_mf_sync` pulse starts a replay in the next cycle. During the replay, `ser_valid` stays high for `4*NCH` cycles. The nibbles are sent for channel 0 upward, and each nibble goes out MSB first (bit 3 is A, bit 0 is D). The half that is read is the published half at the time of the sync.
- R4: While `reins_en` is low, `ser_valid` and `ser_bit` are 0, and a replay in progress is aborted.
- R5: A sync pulse that arrives during a replay restarts the replay from channel 0.
- R6: With `freeze_en` high, `loss_of_frame`, `carrier_loss` or `frame_slip` drives `frozen` high in the same cycle and blocks writes and swaps.
- R7: With `freeze_en` low, the three fault inputs have no effect on `frozen` or on storage.
- R8: `force_freeze` freezes the buffer whatever the value of `freeze_en`.
- R9: After the last cycle with a freeze cause, `frozen` stays high for exactly `HOLD_CYCLES` more cycles. A cause that reappears during this hold restarts the count.
- R10: While frozen, each replay repeats the last published multiframe.
- R11: After reset, `frozen` and `ser_valid` are 0 and every stored nibble is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz backplane clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_valid | input | 1 | Signaling nibble is valid |
| sig_ready | output | 1 | Always 1; the block never back-pressures |
| sig_ch | input | CH_W | Channel index of the nibble |
| sig_nib | input | 4 | ABCD nibble, with A as the MSB |
| rx_mf_end | input | 1 | Pulse that closes the current receive multiframe |
| bp_mf_sync | input | 1 | Backplane multiframe sync pulse |
| loss_of_frame | input | 1 | Frame alignment lost |
| carrier_loss | input | 1 | Carrier lost |
| frame_slip | input | 1 | Frame slip event |
| freeze_en | input | 1 | Allows the fault inputs to freeze the buffer |
| force_freeze | input | 1 | Software-forced freeze |
| reins_en | input | 1 | Enables re-insertion (replay) |
| ser_valid | output | 1 | Serial signaling bit is valid |
| ser_bit | output | 1 | Serial signaling bit |
| frozen | output | 1 | Buffer is frozen, including the hold period |

## Verification
The hardest state to reach from the ports is a boundary that falls partway through a freeze, followed by a release. In that case, the half that was half-written before the fault must never become visible. The bench raises a loss-of-frame fault in the middle of a multiframe and closes that multiframe while the hold is running. It re-triggers the hold with a one-cycle slip, waits out the full 8192-clock hold, and then replays several times. In those replays the reference model must still show the older multiframe until two clean boundaries have passed.

// File: rtl/cas_pkg.sv
package cas_pkg;
  localparam int NIB_W = 4;
  typedef logic [NIB_W-1:0] nibble_t;
endpackage

// File: rtl/cas_freeze_ctl.sv
module cas_freeze_ctl #(
  parameter int HOLD_CYCLES = 8192
) (
  input  logic clk,
  input  logic rst,
  input  logic freeze_en,
  input  logic force_freeze,
  input  logic loss_of_frame,
  input  logic carrier_loss,
  input  logic frame_slip,
  output logic frozen
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYCLES);

  logic          cause;
  logic [CW-1:0] hold_cnt;

  // any active freeze cause this cycle
  assign cause = force_freeze | (freeze_en & (loss_of_frame | carrier_loss | frame_slip));

  always_ff @(posedge clk) begin
    if (rst)                  hold_cnt <= '0;
    else if (cause)           hold_cnt <= HOLD_LD;
    else if (hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;
  end

  assign frozen = cause | (hold_cnt != '0);

  // R9: a cause always leaves the buffer frozen on the following cycle
  a_r9_hold_follows: assert property (@(posedge clk) disable iff (rst)
    cause |=> frozen);
  // R9: release only comes when the hold count reaches its final cycle
  a_r9_release_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(frozen) |-> ($past(hold_cnt) == CW'(1)));
endmodule

// File: rtl/cas_sig_store.sv
module cas_sig_store
  import cas_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frozen,
  input  logic            wr_valid,
  input  logic [CH_W-1:0] wr_ch,
  input  nibble_t         wr_nib,
  input  logic            mf_end,
  output logic            pub_half,
  input  logic            rd_half,
  input  logic [CH_W-1:0] rd_ch,
  output nibble_t         rd_nib
);
  localparam int SLOTS = 2 ** (CH_W + 1);

  logic [SLOTS*NIB_W-1:0] mem_q;
  logic                   wr_sel;
  logic                   clean;
  logic [CH_W:0]          wr_addr;
  logic [CH_W:0]          rd_addr;

  assign wr_addr = {wr_sel, wr_ch};
  assign rd_addr = {rd_half, rd_ch};

  always_ff @(posedge clk) begin
    if (rst)
      mem_q <= '0;
    else if (wr_valid && !frozen)
      mem_q[wr_addr*NIB_W +: NIB_W] <= wr_nib;
  end

  // halves swap only on a boundary that closes a multiframe captured without a freeze
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_sel <= 1'b0;
      clean  <= 1'b0;
    end else if (frozen) begin
      clean  <= 1'b0;
    end else if (mf_end) begin
      if (clean) wr_sel <= ~wr_sel;
      clean <= 1'b1;
    end
  end

  assign pub_half = ~wr_sel;
  assign rd_nib   = mem_q[rd_addr*NIB_W +: NIB_W];

  // R6: no stored nibble changes across a frozen cycle
  a_r6_store_held: assert property (@(posedge clk) disable iff (rst)
    frozen |=> $stable(mem_q));
  // R2: halves never swap while frozen
  a_r2_no_swap_frozen: assert property (@(posedge clk) disable iff (rst)
    frozen |=> $stable(wr_sel));
endmodule

// File: rtl/cas_replay.sv
module cas_replay
  import cas_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reins_en,
  input  logic            bp_sync,
  input  logic            pub_half,
  input  nibble_t         rd_nib,
  output logic            rd_half,
  output logic [CH_W-1:0] rd_ch,
  output logic            ser_valid,
  output logic            ser_bit
);
  localparam int TOTAL = NCH * NIB_W;
  localparam int BW    = $clog2(TOTAL);
  localparam int NB    = $clog2(NIB_W);
  localparam logic [BW-1:0] LAST = BW'(TOTAL - 1);

  logic          active;
  logic [BW-1:0] bit_idx;
  logic [NB-1:0] bsel;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      bit_idx <= '0;
      rd_half <= 1'b0;
    end else if (!reins_en) begin
      active  <= 1'b0;
    end else if (bp_sync) begin
      active  <= 1'b1;
      bit_idx <= '0;
      rd_half <= pub_half;
    end else if (active) begin
      if (bit_idx == LAST) active <= 1'b0;
      else                 bit_idx <= bit_idx + 1'b1;
    end
  end

  assign rd_ch     = CH_W'(int'(bit_idx) / NIB_W);
  assign bsel      = NB'(NIB_W - 1 - (int'(bit_idx) % NIB_W));
  assign ser_valid = active & reins_en;
  assign ser_bit   = ser_valid & rd_nib[bsel];

  // R5: a sync always restarts the replay at its first bit
  a_r5_sync_restart: assert property (@(posedge clk) disable iff (rst)
    (reins_en && bp_sync) |=> (active && bit_idx == '0));
  // R4: with re-insertion off, the replay is dropped
  a_r4_abort: assert property (@(posedge clk) disable iff (rst)
    !reins_en |=> !active);
endmodule

// File: rtl/cas_realign_buf.sv
module cas_realign_buf
  import cas_pkg::*;
#(
  parameter int NCH         = 32,
  parameter int HOLD_CYCLES = 8192,
  parameter int CH_W        = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sig_valid,
  output logic            sig_ready,
  input  logic [CH_W-1:0] sig_ch,
  input  logic [3:0]      sig_nib,
  input  logic            rx_mf_end,
  input  logic            bp_mf_sync,
  input  logic            loss_of_frame,
  input  logic            carrier_loss,
  input  logic            frame_slip,
  input  logic            freeze_en,
  input  logic            force_freeze,
  input  logic            reins_en,
  output logic            ser_valid,
  output logic            ser_bit,
  output logic            frozen
);
  logic            pub_half;
  logic            rd_half;
  logic [CH_W-1:0] rd_ch;
  nibble_t         rd_nib;

  assign sig_ready = 1'b1;

  cas_freeze_ctl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctl (
    .clk(clk), .rst(rst), .freeze_en(freeze_en), .force_freeze(force_freeze),
    .loss_of_frame(loss_of_frame), .carrier_loss(carrier_loss),
    .frame_slip(frame_slip), .frozen(frozen)
  );

  cas_sig_store #(.NCH(NCH), .CH_W(CH_W)) u_store (
    .clk(clk), .rst(rst), .frozen(frozen), .wr_valid(sig_valid),
    .wr_ch(sig_ch), .wr_nib(sig_nib), .mf_end(rx_mf_end),
    .pub_half(pub_half), .rd_half(rd_half), .rd_ch(rd_ch), .rd_nib(rd_nib)
  );

  cas_replay #(.NCH(NCH), .CH_W(CH_W)) u_replay (
    .clk(clk), .rst(rst), .reins_en(reins_en), .bp_sync(bp_mf_sync),
    .pub_half(pub_half), .rd_nib(rd_nib), .rd_half(rd_half), .rd_ch(rd_ch),
    .ser_valid(ser_valid), .ser_bit(ser_bit)
  );

  // R8: a forced freeze is seen at the status output in the same cycle
  a_r8_force_visible: assert property (@(posedge clk) disable iff (rst)
    force_freeze |-> frozen);
  // R4: no valid serial data without re-insertion enabled
  a_r4_no_output_off: assert property (@(posedge clk) disable iff (rst)
    !reins_en |-> (!ser_valid && !ser_bit));
endmodule

// File: tb/sim_cas_realign_buf.sv
module sim_cas_realign_buf;
  localparam int NCH  = 32;
  localparam int HOLD = 8192;
  localparam int TOT  = NCH * 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig_valid = 0, rx_mf_end = 0, bp_mf_sync = 0;
  logic loss_of_frame = 0, carrier_loss = 0, frame_slip = 0;
  logic freeze_en = 0, force_freeze = 0, reins_en = 0;
  logic [4:0] sig_ch = '0;
  logic [3:0] sig_nib = '0;
  logic sig_ready, ser_valid, ser_bit, frozen;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  string cur_req = "R11";

  // reference model state
  int m [0:1][0:NCH-1];
  int w_half, m_clean, m_cnt, m_active, m_idx, m_rd;

  always #4 clk = ~clk;

  cas_realign_buf u0 (
    .clk(clk), .rst(rst), .sig_valid(sig_valid), .sig_ready(sig_ready),
    .sig_ch(sig_ch), .sig_nib(sig_nib), .rx_mf_end(rx_mf_end),
    .bp_mf_sync(bp_mf_sync), .loss_of_frame(loss_of_frame),
    .carrier_loss(carrier_loss), .frame_slip(frame_slip),
    .freeze_en(freeze_en), .force_freeze(force_freeze), .reins_en(reins_en),
    .ser_valid(ser_valid), .ser_bit(ser_bit), .frozen(frozen)
  );

  function automatic bit cause_now();
    return force_freeze || (freeze_en && (loss_of_frame || carrier_loss || frame_slip));
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int h = 0; h < 2; h++) for (int c = 0; c < NCH; c++) m[h][c] = 0;
      w_half = 0; m_clean = 0; m_cnt = 0; m_active = 0; m_idx = 0; m_rd = 0;
    end else begin
      bit cz;
      bit fz;
      int old_w;
      cz = cause_now();
      fz = cz || (m_cnt != 0);
      old_w = w_half;
      if (sig_valid && !fz) m[w_half][sig_ch] = sig_nib;
      if (fz) m_clean = 0;
      else if (rx_mf_end) begin
        if (m_clean != 0) w_half = 1 - w_half;
        m_clean = 1;
      end
      if (cz) m_cnt = HOLD; else if (m_cnt != 0) m_cnt--;
      if (!reins_en) m_active = 0;
      else if (bp_mf_sync) begin m_active = 1; m_idx = 0; m_rd = 1 - old_w; end
      else if (m_active != 0) begin
        if (m_idx == TOT - 1) m_active = 0; else m_idx++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      bit e_frz, e_val, e_bit;
      e_frz = cause_now() || (m_cnt != 0);
      e_val = (m_active != 0) && reins_en;
      e_bit = e_val ? 1'(m[m_rd][m_idx / 4] >> (3 - m_idx % 4)) : 1'b0;
      vectors++;
      if (ser_valid !== e_val || ser_bit !== e_bit || frozen !== e_frz || sig_ready !== 1'b1) begin
        miscompares++;
        $display("FAIL %s cyc=%0d valid=%b/%b bit=%b/%b frozen=%b/%b ready=%b/1",
                 cur_req, cycles, ser_valid, e_val, ser_bit, e_bit, frozen, e_frz, sig_ready);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic send_mf(int base, int fault_at = -1);
    for (int c = 0; c < NCH; c++) begin
      if (c == fault_at) loss_of_frame = 1;
      if (c == fault_at + 5) loss_of_frame = 0;
      sig_valid = 1; sig_ch = 5'(c); sig_nib = 4'(base + c * 3);
      step();
    end
    sig_valid = 0;
    rx_mf_end = 1; step(); rx_mf_end = 0;
  endtask

  task automatic replay(int n = TOT + 8);
    bp_mf_sync = 1; step(); bp_mf_sync = 0; step(n);
  endtask

  initial begin
    step(4); rst = 0;
    cur_req = "R11"; reins_en = 1; replay();
    cur_req = "R1"; send_mf(1);
    cur_req = "R2"; send_mf(5); replay();
    cur_req = "R3"; send_mf(9); replay();
    cur_req = "R5"; bp_mf_sync = 1; step(); bp_mf_sync = 0; step(40); replay();
    cur_req = "R4"; bp_mf_sync = 1; step(); bp_mf_sync = 0; step(20);
    reins_en = 0; step(20); reins_en = 1; step(10);
    cur_req = "R6"; freeze_en = 1; send_mf(2, 10);
    cur_req = "R10"; replay(); send_mf(7); replay();
    cur_req = "R9"; step(2000); frame_slip = 1; step(); frame_slip = 0;
    step(HOLD - 3); step(10);
    send_mf(3); send_mf(11); replay();
    cur_req = "R7"; freeze_en = 0; carrier_loss = 1; send_mf(4); replay();
    carrier_loss = 0;
    cur_req = "R8"; force_freeze = 1; step(10); force_freeze = 0;
    send_mf(6); replay(); step(HOLD); send_mf(13); send_mf(14); replay();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule